// File: doc/BRIEF.md
# Core-Side Store Data Queue with Delayed Flush

This block receives store data words, each with a 4-bit tag and a 64-bit payload, from an attached coprocessor and holds them in a small first-in first-out queue. The load/store unit drains the queue through a valid/ready handshake. Entries leave in arrival order, and each one keeps its tag.

The sender sees a registered back-pressure output, `stop_o`. The path from the block back to the sender takes one cycle, so one more word may arrive after `stop_o` rises. With three slots and a threshold of two occupied entries, that late word always has a place.

When the core decides to discard in-progress stores, it pulses `flush_i`. Words already on their way keep arriving for two more cycles. The queue stores them as usual and then clears itself completely on the second clock edge after the notice. Any word offered on that clearing edge is dropped. If a further notice comes in while a clear is still pending, the two-cycle wait starts again from the newer notice.

Top module: `sdq_top`

## Requirements
- R1: After a synchronous reset, `out_vld_o`, `stop_o` and `ovf_o` are all 0 and the queue holds no entries.
- R2: The queue stores up to 3 entries. A word offered with `in_vld_i`=1 is taken on the clock edge whenever fewer than 3 entries are held.
- R3: In the cycle after any clock edge, `stop_o` is 1 exactly when that edge left 2 or more entries in the queue.
- R4: The head entry appears on `out_tag_o`/`out_data_o` while `out_vld_o`=1. `out_vld_o` is 1 whenever the queue is not empty. An edge with `out_vld_o`=1 and `out_rdy_i`=1 removes the head. Entries leave in arrival order.
- R5: When `flush_i` is sampled at edge E, words at edge E and E+1 are stored normally. At edge E+2 the queue becomes empty, and a word offered at E+2 is discarded without setting the error flag.
- R6: A `flush_i` pulse sampled while a clear is pending restarts the wait. The clear happens two edges after the newest notice and not at the earlier scheduled edge.
- R7: A word offered when 3 entries are held and no entry leaves on the same edge is dropped. It sets `ovf_o`, which stays 1 until reset.
- R8: A sender that acts on the value of `stop_o` from one cycle earlier never causes `ovf_o` to rise.
- R9: On an edge where the queue is full, a word is offered and the head is removed, the word is accepted and the queue stays full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld_i | input | 1 | Store word offered by the coprocessor |
| in_tag_i | input | 4 | Tag of the offered word |
| in_data_i | input | 64 | Payload of the offered word |
| stop_o | output | 1 | Registered back-pressure toward the sender |
| flush_i | input | 1 | Flush notice for pending stores |
| out_vld_o | output | 1 | Head entry available |
| out_rdy_i | input | 1 | Load/store unit takes the head entry |
| out_tag_o | output | 4 | Tag of the head entry |
| out_data_o | output | 64 | Payload of the head entry |
| ovf_o | output | 1 | Sticky flag: a word arrived with no room |

## Verification
A wrong occupancy count shows up at the ports in the very next cycle, in one of three ways. `stop_o` takes the wrong level, `out_vld_o` disagrees with the number of words still owed, or `ovf_o` rises when it should not. A wrong read or write pointer shows up the first time a word reaches the head, as a tag or payload out of order. A wrong flush counter clears the queue one edge early or one edge late. That error is visible as `out_vld_o` at the edge just after the expected clear, or as surviving and vanishing words in the cycle that follows.

// File: rtl/sdq_pkg.sv
package sdq_pkg;
  localparam int unsigned SDQ_TAG_W     = 4;
  localparam int unsigned SDQ_DATA_W    = 64;
  localparam int unsigned SDQ_DEPTH     = 3;
  localparam int unsigned SDQ_FLUSH_DLY = 2;
endpackage

// File: rtl/sdq_mem.sv
module sdq_mem #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned W     = 68,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  assign rdata = slots[raddr];
endmodule

// File: rtl/sdq_flush_timer.sv
module sdq_flush_timer #(
  parameter int unsigned DLY = 2,
  localparam int unsigned TW = $clog2(DLY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic flush_i,
  output logic clear_o
);
  logic [TW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                   remain_q <= '0;
    else if (flush_i)          remain_q <= TW'(DLY);
    else if (remain_q != '0)   remain_q <= remain_q - 1'b1;
  end

  // clear fires on the edge where the countdown expires, unless a fresh notice restarts it
  assign clear_o = (remain_q == TW'(1)) && !flush_i;

  if (DLY > 1) begin : g_chk
    assert_no_early_clear_R6: assert property (@(posedge clk) disable iff (rst)
      flush_i |=> !clear_o);
  end
endmodule

// File: rtl/sdq_ctrl.sv
module sdq_ctrl #(
  parameter int unsigned DEPTH    = 3,
  parameter int unsigned STOP_LVL = 2,
  localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          rdy_i,
  input  logic          clear_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic          vld_o,
  output logic          stop_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [AW-1:0] wp_q, rp_q;
  logic          stop_q, ovf_q;
  logic          pop, full, take, lost;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = (cnt_q == CW'(DEPTH));
  assign pop  = rdy_i && (cnt_q != '0);
  assign take = push_i && !clear_i && (!full || pop);
  assign lost = push_i && !clear_i && full && !pop;

  always_comb begin
    if (clear_i) cnt_nx = '0;
    else         cnt_nx = cnt_q + CW'(take) - CW'(pop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      wp_q   <= '0;
      rp_q   <= '0;
      stop_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      stop_q <= (cnt_nx >= CW'(STOP_LVL));
      if (lost) ovf_q <= 1'b1;
      if (clear_i) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (take) wp_q <= wrap_inc(wp_q);
        if (pop)  rp_q <= wrap_inc(rp_q);
      end
    end
  end

  assign wr_en_o  = take;
  assign wr_ptr_o = wp_q;
  assign rd_ptr_o = rp_q;
  assign vld_o    = (cnt_q != '0);
  assign stop_o   = stop_q;
  assign ovf_o    = ovf_q;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_stop_level_R3: assert property (@(posedge clk) disable iff (rst)
    stop_q == (cnt_q >= CW'(STOP_LVL)));
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (cnt_q == '0));
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  assert_full_swap_R9: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && rdy_i && !clear_i) |=> (cnt_q == CW'(DEPTH)));
  assert_last_pop_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(1) && rdy_i && !push_i) |=> !vld_o);
endmodule

// File: rtl/sdq_top.sv
module sdq_top #(
  parameter int unsigned TAG_W     = sdq_pkg::SDQ_TAG_W,
  parameter int unsigned DATA_W    = sdq_pkg::SDQ_DATA_W,
  parameter int unsigned DEPTH     = sdq_pkg::SDQ_DEPTH,
  parameter int unsigned FLUSH_DLY = sdq_pkg::SDQ_FLUSH_DLY,
  localparam int unsigned STOP_LVL = DEPTH - 1,
  localparam int unsigned EW       = TAG_W + DATA_W,
  localparam int unsigned AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld_i,
  input  logic [TAG_W-1:0]  in_tag_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              stop_o,
  input  logic              flush_i,
  output logic              out_vld_o,
  input  logic              out_rdy_i,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              ovf_o
);
  logic          clear;
  logic          wr_en;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [EW-1:0] head;

  sdq_flush_timer #(.DLY(FLUSH_DLY)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .flush_i (flush_i),
    .clear_o (clear)
  );

  sdq_ctrl #(.DEPTH(DEPTH), .STOP_LVL(STOP_LVL)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .push_i   (in_vld_i),
    .rdy_i    (out_rdy_i),
    .clear_i  (clear),
    .wr_en_o  (wr_en),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .vld_o    (out_vld_o),
    .stop_o   (stop_o),
    .ovf_o    (ovf_o)
  );

  sdq_mem #(.DEPTH(DEPTH), .W(EW)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata ({in_tag_i, in_data_i}),
    .raddr (rd_ptr),
    .rdata (head)
  );

  assign {out_tag_o, out_data_o} = head;
endmodule

// File: tb/sim_sdq_top.sv
`timescale 1ns/1ps
module sim_sdq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [3:0]  in_tag = '0;
  logic [63:0] in_data = '0;
  logic        flush = 1'b0;
  logic        out_rdy = 1'b0;
  logic        stop, out_vld, ovf;
  logic [3:0]  out_tag;
  logic [63:0] out_data;

  always #2.5 clk = ~clk;

  sdq_top u0 (
    .clk(clk), .rst(rst), .in_vld_i(in_vld), .in_tag_i(in_tag), .in_data_i(in_data),
    .stop_o(stop), .flush_i(flush), .out_vld_o(out_vld), .out_rdy_i(out_rdy),
    .out_tag_o(out_tag), .out_data_o(out_data), .ovf_o(ovf)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string req = "R4";

  logic [67:0] mq [3];
  int mcnt, mtim;
  bit mstop, movf;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL R4 watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(bit ok, string r, logic [67:0] act, logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 0; flush = 0; out_rdy = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0;
    mcnt = 0; mtim = 0; mstop = 0; movf = 0;
  endtask

  // drive one cycle, compare against model state, advance model, pass one edge
  task automatic step(bit v, logic [3:0] t, logic [63:0] d, bit rdy, bit fl);
    bit clr, pop;
    in_vld = v; in_tag = t; in_data = d; out_rdy = rdy; flush = fl;
    #1;
    chk(out_vld == (mcnt != 0), req, 68'(out_vld), 68'(mcnt != 0));
    if (mcnt != 0) chk({out_tag, out_data} == mq[0], req, {out_tag, out_data}, mq[0]);
    chk(stop == mstop, "R3", 68'(stop), 68'(mstop));
    chk(ovf == movf, "R7", 68'(ovf), 68'(movf));
    clr = (mtim == 1) && !fl;
    pop = rdy && (mcnt > 0);
    if (fl) mtim = 2; else if (mtim > 0) mtim--;
    if (clr) mcnt = 0;
    else begin
      if (pop) begin
        mq[0] = mq[1]; mq[1] = mq[2]; mcnt--;
      end
      if (v) begin
        if (mcnt < 3) begin mq[mcnt] = {t, d}; mcnt++; end
        else movf = 1;
      end
    end
    mstop = (mcnt >= 2);
    @(posedge clk); #1;
  endtask

  function automatic logic [63:0] pat(int i);
    return {32'hC0DE_0000 + 32'(i), ~32'(i * 7)};
  endfunction

  initial begin
    bit sv_old, v;
    do_reset();
    // R1 reset state
    chk(out_vld == 0, "R1", 68'(out_vld), 0);
    chk(stop == 0, "R1", 68'(stop), 0);
    chk(ovf == 0, "R1", 68'(ovf), 0);

    // R2 fill to capacity, R9 swap at full, R7 overflow
    req = "R2";
    for (int i = 1; i <= 3; i++) step(1, 4'(i), pat(i), 0, 0);
    chk(out_vld == 1 && out_tag == 4'd1, "R2", 68'(out_tag), 1);
    chk(stop == 1, "R3", 68'(stop), 1);
    req = "R9";
    step(1, 4'd4, pat(4), 1, 0);
    chk(out_tag == 4'd2 && ovf == 0, "R9", 68'({ovf, out_tag}), 2);
    req = "R7";
    step(1, 4'd5, pat(5), 0, 0);
    chk(ovf == 1, "R7", 68'(ovf), 1);
    req = "R4";
    for (int i = 2; i <= 4; i++) begin
      chk(out_tag == 4'(i) && out_data == pat(i), "R4", {out_tag, out_data}, {4'(i), pat(i)});
      step(0, 0, 0, 1, 0);
    end
    chk(out_vld == 0, "R4", 68'(out_vld), 0);

    // R8 sender reacting to stop one cycle late
    do_reset();
    req = "R8";
    sv_old = 0;
    for (int i = 0; i < 2000; i++) begin
      v = !sv_old && ($urandom % 4 != 0);
      sv_old = stop;
      step(v, 4'($urandom), {$urandom, $urandom}, ($urandom % 3) == 0, 0);
    end
    chk(ovf == 0, "R8", 68'(ovf), 0);

    // R5 delayed clear swallows in-flight words
    do_reset();
    req = "R5";
    step(1, 4'hA, pat(10), 0, 0);
    step(1, 4'hB, pat(11), 0, 1);
    step(1, 4'hC, pat(12), 0, 0);
    chk(out_vld == 1 && stop == 1, "R5", 68'({out_vld, stop}), 3);
    step(1, 4'hD, pat(13), 0, 0);
    chk(out_vld == 0 && ovf == 0, "R5", 68'({out_vld, ovf}), 0);
    step(1, 4'hE, pat(14), 0, 0);
    chk(out_vld == 1 && out_tag == 4'hE, "R5", 68'(out_tag), 68'(4'hE));

    // R6 restart of the wait
    do_reset();
    req = "R6";
    step(1, 4'h1, pat(20), 0, 1);
    step(1, 4'h2, pat(21), 0, 1);
    step(0, 0, 0, 0, 0);
    chk(out_vld == 1 && out_tag == 4'h1, "R6", 68'({out_vld, out_tag}), 68'(5'h11));
    step(0, 0, 0, 0, 0);
    chk(out_vld == 0, "R6", 68'(out_vld), 0);

    // mixed sweep: order, stop, overflow, flush interplay
    do_reset();
    req = "R4";
    for (int i = 0; i < 4000; i++)
      step(1'($urandom), 4'($urandom), {$urandom, $urandom}, 1'($urandom), ($urandom % 23) == 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule